// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside a small 8-bit microcontroller core and runs its two sleep states. Software requests a state by writing a two-bit control value. In the light sleep state (idle) the CPU is frozen while the peripheral clock and the oscillator keep running. In the deep sleep state (power-down) the oscillator is also stopped and the peripheral clock is gated. The block watches the hardware reset, the pending enabled interrupt and the two external interrupt pins to decide when to wake. It also drives override values for the address-latch and program-fetch strobes and for the port drivers while the core sleeps.

Waking from power-down through an external pin has two phases. While a qualifying pin is held low the oscillator runs again. The CPU is released only after a programmable count of stable oscillator cycles has elapsed and the pin has returned high. A hardware reset during idle blocks internal RAM writes for as long as the reset is held. Port writes stay allowed in that window.

Top module: `lpm_ctrl`

## Requirements
- R1: After rst_n the block is running: ctl_q=00, cpu_hold=0, periph_clk_en=1, osc_run=1, strobe_ovr=0, port0_float=0, port2_addr=0, ram_wr_block=0.
- R2: In the running state, a write with ctl_wdata=01 and hw_rst low enters idle on the next clock. Idle drives cpu_hold=1, periph_clk_en=1, osc_run=1, strobe_ovr=1 and strobe_lvl=1, and ctl_q reads 01.
- R3: In the running state, a write with ctl_wdata bit 1 set (10 or 11) enters power-down on the next clock, so power-down wins over idle. Power-down drives osc_run=0, periph_clk_en=0, cpu_hold=1, strobe_ovr=1 and strobe_lvl=0, and ctl_q holds the written value.
- R4: In idle, irq_pending=1 returns the block to running on the next clock and clears ctl_q to 00.
- R5: In idle, hw_rst=1 sets ram_wr_block=1 in the same cycle. It stays 1 while hw_rst is held, with strobe_ovr=0. After hw_rst falls the block is running with ctl_q=00.
- R6: In power-down, pin i wakes the block only when ext_n[i]=0, ext_en[i]=1 and ext_level[i]=1. Any other pin pattern and irq_pending leave osc_run=0 and ctl_q unchanged.
- R7: A wake enters the warm-up state on the next clock, with osc_run=1, cpu_hold=1 and periph_clk_en=0. Count the clocks from that entry clock as 0. cpu_hold falls at clock max(N+1, p), where N=stable_cycles and p is the first clock that samples every qualifying pin high. ctl_q is then 00.
- R8: In power-down or warm-up, hw_rst=1 returns the block to running on the next clock with ctl_q=00.
- R9: port0_float equals ext_prog in idle, power-down and warm-up. port2_addr equals ext_prog in idle only. Both are 0 while running.
- R10: Control writes are ignored while hw_rst=1 and when ctl_wdata=00. The block stays running with ctl_q=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst | input | 1 | Synchronous hardware reset request |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| irq_pending | input | 1 | Some enabled interrupt is pending |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_en | input | 2 | Per-pin interrupt enable |
| ext_level | input | 2 | Per-pin level-sensitive mode (1) |
| ext_prog | input | 1 | Core fetches from external program memory |
| stable_cycles | input | CNT_W | Oscillator-stable cycles to wait before release |
| ctl_q | output | 2 | Control register readback |
| cpu_hold | output | 1 | Freeze the CPU clock |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run request |
| strobe_ovr | output | 1 | Override the address-latch and fetch strobes |
| strobe_lvl | output | 1 | Level forced on both strobes |
| port0_float | output | 1 | Tri-state port 0 |
| port2_addr | output | 1 | Port 2 drives address instead of latched data |
| ram_wr_block | output | 1 | Inhibit internal RAM writes |

## Verification
The assertions assume that every input is synchronous to clk and settles between edges. They also assume that hw_rst is a clean level, and that stable_cycles does not change while a warm-up is in progress. The bench changes every input on the falling edge and samples outputs there. It alters stable_cycles only while the block is running. It sweeps all 64 pin, enable and mode combinations, and crosses warm-up counts 0 to 4 with pin-release delays 0 to 6.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_wdata,
  input  logic             irq_pending,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       ext_en,
  input  logic [1:0]       ext_level,
  input  logic             ext_prog,
  input  logic [CNT_W-1:0] stable_cycles,
  output logic [1:0]       ctl_q,
  output logic             cpu_hold,
  output logic             periph_clk_en,
  output logic             osc_run,
  output logic             strobe_ovr,
  output logic             strobe_lvl,
  output logic             port0_float,
  output logic             port2_addr,
  output logic             ram_wr_block
);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PD, S_WARM, S_RBLK} st_t;

  st_t             st, nxt;
  logic [CNT_W-1:0] cnt;
  logic             wake_low, ready, req_ok;

  assign wake_low = |(~ext_n & ext_en & ext_level);
  assign ready    = (cnt == stable_cycles);
  assign req_ok   = ctl_wr && !hw_rst;

  always_comb begin
    nxt = st;
    case (st)
      S_RUN:  if (req_ok && ctl_wdata[1]) nxt = S_PD;
              else if (req_ok && ctl_wdata[0]) nxt = S_IDLE;
      S_IDLE: if (hw_rst) nxt = S_RBLK;
              else if (irq_pending) nxt = S_RUN;
      S_PD:   if (hw_rst) nxt = S_RUN;
              else if (wake_low) nxt = S_WARM;
      S_WARM: if (hw_rst || (ready && !wake_low)) nxt = S_RUN;
      S_RBLK: if (!hw_rst) nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_RUN;
      ctl_q <= 2'b00;
      cnt   <= '0;
    end else begin
      st <= nxt;
      if (st == S_RUN && nxt != S_RUN) ctl_q <= ctl_wdata;
      else if (nxt == S_RUN)           ctl_q <= 2'b00;
      if (st != S_WARM)  cnt <= '0;
      else if (!ready)   cnt <= cnt + 1'b1;
    end
  end

  assign cpu_hold      = (st != S_RUN);
  assign periph_clk_en = (st == S_RUN) || (st == S_IDLE) || (st == S_RBLK);
  assign osc_run       = (st != S_PD);
  assign strobe_ovr    = (st == S_IDLE) || (st == S_PD) || (st == S_WARM);
  assign strobe_lvl    = (st == S_IDLE);
  assign port0_float   = ext_prog && strobe_ovr;
  assign port2_addr    = ext_prog && (st == S_IDLE);
  assign ram_wr_block  = hw_rst && ((st == S_IDLE) || (st == S_RBLK));

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_rst,
  input logic       ctl_wr,
  input logic [1:0] ctl_wdata,
  input logic       irq_pending,
  input logic [1:0] ext_n,
  input logic [1:0] ext_en,
  input logic [1:0] ext_level,
  input logic       ext_prog,
  input logic       cpu_hold,
  input logic       periph_clk_en,
  input logic       osc_run,
  input logic       strobe_ovr,
  input logic       strobe_lvl,
  input logic       port2_addr,
  input logic       ram_wr_block
);
  logic wake;
  assign wake = |(~ext_n & ext_en & ext_level);

  // R2
  idle_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && ctl_wr && ctl_wdata == 2'b01 && !hw_rst) |=> (cpu_hold && periph_clk_en && osc_run));
  // R3
  pd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> (cpu_hold && !periph_clk_en && strobe_ovr && !strobe_lvl));
  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ovr && strobe_lvl && irq_pending && !hw_rst) |=> !cpu_hold);
  // R5
  ram_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_block |-> hw_rst);
  // R6
  pd_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && !hw_rst && !wake) |=> !osc_run);
  // R7
  warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && !periph_clk_en && wake && !hw_rst) |=> cpu_hold);
  // R8
  pd_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_clk_en && hw_rst) |=> !cpu_hold);
  // R9
  port2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port2_addr |-> (ext_prog && strobe_ovr && strobe_lvl));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .irq_pending(irq_pending), .ext_n(ext_n), .ext_en(ext_en), .ext_level(ext_level),
  .ext_prog(ext_prog), .cpu_hold(cpu_hold), .periph_clk_en(periph_clk_en),
  .osc_run(osc_run), .strobe_ovr(strobe_ovr), .strobe_lvl(strobe_lvl),
  .port2_addr(port2_addr), .ram_wr_block(ram_wr_block)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;

  logic clk = 0, rst_n = 0, hw_rst = 0, ctl_wr = 0, irq_pending = 0, ext_prog = 0;
  logic [1:0] ctl_wdata = 0, ext_n = 2'b11, ext_en = 2'b11, ext_level = 2'b11;
  logic [CNT_W-1:0] stable_cycles = 0;
  logic [1:0] ctl_q;
  logic cpu_hold, periph_clk_en, osc_run, strobe_ovr, strobe_lvl, port0_float, port2_addr, ram_wr_block;
  int n_chk = 0, n_bad = 0;

  lpm_ctrl #(.CNT_W(CNT_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [1:0] v);
    ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic home();
    ext_n = 2'b11; irq_pending = 0; hw_rst = 1; tick(); hw_rst = 0; tick();
  endtask

  // packs {ctl_q, cpu_hold, periph_clk_en, osc_run, strobe_ovr, strobe_lvl}
  function automatic int vec();
    return {ctl_q, cpu_hold, periph_clk_en, osc_run, strobe_ovr, strobe_lvl};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    // R1
    chk("R1 state", vec(), 7'b00_0_1_1_0_0);
    chk("R1 ports", {port0_float, port2_addr, ram_wr_block}, 0);

    for (int p = 0; p < 2; p++) begin
      ext_prog = p[0];
      wr(2'b01);
      chk("R2 idle", vec(), 7'b01_1_1_1_1_1);
      chk("R9 idle ports", {port0_float, port2_addr}, {p[0], p[0]});
      irq_pending = 1; tick(); irq_pending = 0;
      chk("R4 idle wake", vec(), 7'b00_0_1_1_0_0);
      chk("R9 run ports", {port0_float, port2_addr}, 0);
      for (int v = 2; v < 4; v++) begin
        wr(v[1:0]);
        chk("R3 pd", vec(), {v[1:0], 5'b1_0_0_1_0});
        chk("R9 pd ports", {port0_float, port2_addr}, {p[0], 1'b0});
        home();
      end
    end
    ext_prog = 0;

    // R5 reset out of idle
    wr(2'b01); hw_rst = 1; #1;
    chk("R5 block same cycle", ram_wr_block, 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 block held", {ram_wr_block, strobe_ovr}, 2'b10);
    end
    hw_rst = 0; #1;
    chk("R5 block released", ram_wr_block, 0);
    tick();
    chk("R5 run after", vec(), 7'b00_0_1_1_0_0);

    // R10 ignored writes
    hw_rst = 1; wr(2'b01); hw_rst = 0;
    chk("R10 write under reset", vec(), 7'b00_0_1_1_0_0);
    wr(2'b00);
    chk("R10 zero write", vec(), 7'b00_0_1_1_0_0);

    // R6 and R8: every pin/enable/mode combination
    for (int c = 0; c < 64; c++) begin
      logic [1:0] en, lv, lo;
      logic exp_w;
      en = c[1:0]; lv = c[3:2]; lo = c[5:4];
      exp_w = |(en & lv & lo);
      ext_en = en; ext_level = lv;
      wr(2'b10);
      ext_n = ~lo; irq_pending = 1; tick();
      chk("R6 wake qualify", osc_run, exp_w);
      tick();
      chk("R6 ctl kept", {ctl_q, cpu_hold}, 3'b101);
      hw_rst = 1; tick(); hw_rst = 0; irq_pending = 0; ext_n = 2'b11;
      chk("R8 reset exit", {ctl_q, cpu_hold}, 0);
      tick();
    end
    ext_en = 2'b11; ext_level = 2'b11;

    // R7 warm-up timing sweep
    for (int n = 0; n < 5; n++) begin
      for (int h = 0; h < 7; h++) begin
        int e;
        stable_cycles = n[CNT_W-1:0];
        e = (n + 1 > h + 1) ? n + 1 : h + 1;
        wr(2'b10);
        ext_n = {1'b1, h[0]} ^ 2'b11 | 2'b10;
        ext_n = (h % 2 == 0) ? 2'b10 : 2'b01;
        tick();
        chk("R7 warm entry", {cpu_hold, periph_clk_en, osc_run}, 3'b101);
        for (int j = 1; j <= e; j++) begin
          if (j == h + 1) ext_n = 2'b11;
          tick();
          chk("R7 release timing", cpu_hold, (j < e) ? 1 : 0);
        end
        chk("R7 ctl cleared", ctl_q, 0);
        tick();
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule